// File: doc/BRIEF.md
# Register-File LIFO Stack with Occupancy Flags

This block is a last-in first-out store of 64 words of 8 bits, built from flip-flops. A 6-bit pointer names the word at the top of the stack. The pointer wraps in both directions, so incrementing 63 gives 0 and decrementing 0 gives 63. Because of this the pointer alone cannot tell an empty stack from a full one. Two one-bit flags, full and empty, carry that information.

A push first advances the pointer and then stores the input byte at the new pointer value. The first item pushed therefore lands at address 1, and the 64th lands at address 0. A pop reads the word under the pointer into an output data register and then steps the pointer back.

A request is refused when the flags forbid it: a push while full, or a pop while empty. A request is also refused when push and pop are raised in the same cycle. A refused request changes no state and raises a one-cycle error pulse. The surrounding logic drives one request per cycle and watches the flags to know when the stack can accept more.

Top module: `stk_reg_stack`

## Requirements
- R1: While reset is asserted, and after it is released with no request made, the outputs are sp_o=0, empty_o=1, full_o=0, err_o=0 and dout_o=0x00.
- R2: A push with pop_i=0 and full_o=0 is accepted. On the next edge sp_o becomes (sp_o+1) mod 64, empty_o becomes 0, and full_o becomes 1 exactly when the new sp_o is 0.
- R3: A pop with push_i=0 and empty_o=0 is accepted. On the next edge dout_o takes the word stored at the current sp_o, sp_o becomes (sp_o-1) mod 64, full_o becomes 0, and empty_o becomes 1 exactly when the new sp_o is 0.
- R4: Items come back in the reverse of the order in which they were pushed, across all 64 entries.
- R5: A push while full_o=1 is refused: sp_o, full_o, empty_o and dout_o keep their values.
- R6: A pop while empty_o=1 is refused: sp_o, full_o, empty_o and dout_o keep their values.
- R7: When push_i and pop_i are both high in the same cycle, both are ignored and no state changes.
- R8: err_o is 1 in the cycle after any refused request (R5, R6, R7) and 0 in the cycle after any other cycle.
- R9: The first item pushed onto an empty stack leaves sp_o=1. After 64 pushes sp_o=0 with full_o=1, and full_o and empty_o are never 1 together.
- R10: dout_o changes only on an accepted pop. Pushes and refused requests leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| din_i | input | 8 | Byte to push |
| dout_o | output | 8 | Data register holding the most recently popped byte |
| full_o | output | 1 | Stack holds 64 items |
| empty_o | output | 1 | Stack holds no items |
| sp_o | output | 6 | Current top-of-stack pointer |
| err_o | output | 1 | One-cycle pulse after a refused request |

## Verification
The assertions check four things on every cycle: the pointer step and flag update after each accepted push or pop, the frozen state and error pulse after each refused or colliding request, the rule that the output register moves only on an accepted pop, and the rule that a flag is set only when the pointer is zero. Properties cannot see the stored contents. LIFO ordering over a full fill and drain, the placement of the 64th item at address 0, and the return of the correct byte on each pop can only be shown by the bench's scenarios, which push known patterns and compare every popped byte.

// File: rtl/stk_pkg.sv
package stk_pkg;

  // Decoded request class for one cycle
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_PUSH   = 2'd1,
    OP_POP    = 2'd2,
    OP_REJECT = 2'd3
  } stk_op_e;

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic             rd_en_o,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic [PTR_W-1:0] sp_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             err_o
);

  logic [PTR_W-1:0] sp_q, sp_d;
  logic [PTR_W-1:0] sp_inc, sp_dec;
  logic             full_q, full_d;
  logic             empty_q, empty_d;
  logic             err_q, err_d;
  stk_op_e          op;

  assign sp_inc = sp_q + 1'b1;
  assign sp_dec = sp_q - 1'b1;

  // Classify the request against the current flags
  always_comb begin
    op = OP_IDLE;
    if (push_i && pop_i) begin
      op = OP_REJECT;
    end else if (push_i) begin
      op = full_q ? OP_REJECT : OP_PUSH;
    end else if (pop_i) begin
      op = empty_q ? OP_REJECT : OP_POP;
    end
  end

  // Next-state logic for pointer and flags
  always_comb begin
    sp_d    = sp_q;
    full_d  = full_q;
    empty_d = empty_q;
    err_d   = (op == OP_REJECT);
    unique case (op)
      OP_PUSH: begin
        sp_d    = sp_inc;
        full_d  = (sp_inc == '0);
        empty_d = 1'b0;
      end
      OP_POP: begin
        sp_d    = sp_dec;
        empty_d = (sp_dec == '0);
        full_d  = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      sp_q    <= sp_d;
      full_q  <= full_d;
      empty_q <= empty_d;
      err_q   <= err_d;
    end
  end

  assign wr_en_o   = (op == OP_PUSH);
  assign wr_addr_o = sp_inc;
  assign rd_en_o   = (op == OP_POP);
  assign rd_addr_o = sp_q;
  assign sp_o      = sp_q;
  assign full_o    = full_q;
  assign empty_o   = empty_q;
  assign err_o     = err_q;

endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] words [DEPTH];

  // One enabled register per stack word, no reset on storage
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              word_en;

    assign word_en = we_i && (waddr_i == PTR_W'(g));

    always_ff @(posedge clk) begin
      if (word_en) begin
        word_q <= wdata_i;
      end
    end

    assign words[g] = word_q;
  end

  assign rdata_o = words[raddr_i];

endmodule

// File: rtl/stk_dreg.sv
module stk_dreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (en_i) begin
      q_d = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
    end else begin
      q_o <= q_d;
    end
  end

endmodule

// File: rtl/stk_reg_stack.sv
module stk_reg_stack #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [PTR_W-1:0]  sp_o,
  output logic              err_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr;
  logic              rd_en;
  logic [PTR_W-1:0]  rd_addr;
  logic [DATA_W-1:0] rd_data;

  // Assert asynchronously, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  stk_ctrl #(.PTR_W(PTR_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr),
    .sp_o      (sp_o),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .err_o     (err_o)
  );

  stk_regfile #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_regfile (
    .clk     (clk),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (din_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  stk_dreg #(.DATA_W(DATA_W)) i_dreg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en_i  (rd_en),
    .d_i   (rd_data),
    .q_o   (dout_o)
  );

endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_i,
  input logic              pop_i,
  input logic [DATA_W-1:0] dout_o,
  input logic              full_o,
  input logic              empty_o,
  input logic [PTR_W-1:0]  sp_o,
  input logic              err_o
);

  logic push_ok, pop_ok, refused;

  assign push_ok = push_i && !pop_i && !full_o;
  assign pop_ok  = pop_i && !push_i && !empty_o;
  assign refused = (push_i && pop_i) || (push_i && full_o) || (pop_i && empty_o);

  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> (sp_o == PTR_W'($past(sp_o) + 1'b1)) && !empty_o && (full_o == (sp_o == '0)));

  p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> (sp_o == PTR_W'($past(sp_o) - 1'b1)) && !full_o && (empty_o == (sp_o == '0)));

  // Covers R5, R6 and R7
  p_refuse_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> $stable(sp_o) && $stable(full_o) && $stable(empty_o) && $stable(dout_o));

  p_err_on_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> err_o);

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !refused |=> !err_o);

  p_dout_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_ok |=> $stable(dout_o));

  p_flags_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o || empty_o) |-> (sp_o == '0) && !(full_o && empty_o));

endmodule

bind stk_reg_stack stk_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .push_i  (push_i),
  .pop_i   (pop_i),
  .dout_o  (dout_o),
  .full_o  (full_o),
  .empty_o (empty_o),
  .sp_o    (sp_o),
  .err_o   (err_o)
);

// File: tb/test_stk_reg_stack.sv
`timescale 1ns/1ps
module test_stk_reg_stack;

  logic       clk;
  logic       rst_n;
  logic       push_i;
  logic       pop_i;
  logic [7:0] din_i;
  logic [7:0] dout_o;
  logic       full_o;
  logic       empty_o;
  logic [5:0] sp_o;
  logic       err_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  stk_reg_stack i_stk_reg_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .din_i   (din_i),
    .dout_o  (dout_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .sp_o    (sp_o),
    .err_o   (err_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Vector: push, pop, din, exp sp, exp full, exp empty, exp err, exp dout
  localparam int NVEC = 11;
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'h00, 6'd0, 1'b0, 1'b1, 1'b0, 8'h00},  // idle
    {1'b0, 1'b1, 8'h00, 6'd0, 1'b0, 1'b1, 1'b1, 8'h00},  // pop empty R6
    {1'b1, 1'b0, 8'hA5, 6'd1, 1'b0, 1'b0, 1'b0, 8'h00},  // push R2 R9
    {1'b1, 1'b0, 8'h3C, 6'd2, 1'b0, 1'b0, 1'b0, 8'h00},  // push R2
    {1'b1, 1'b1, 8'h77, 6'd2, 1'b0, 1'b0, 1'b1, 8'h00},  // both R7
    {1'b0, 1'b1, 8'h00, 6'd1, 1'b0, 1'b0, 1'b0, 8'h3C},  // pop R3
    {1'b1, 1'b0, 8'h81, 6'd2, 1'b0, 1'b0, 1'b0, 8'h3C},  // push keeps dout R10
    {1'b0, 1'b1, 8'h00, 6'd1, 1'b0, 1'b0, 1'b0, 8'h81},  // pop R4
    {1'b0, 1'b1, 8'h00, 6'd0, 1'b0, 1'b1, 1'b0, 8'hA5},  // pop to empty R3
    {1'b0, 1'b1, 8'h00, 6'd0, 1'b0, 1'b1, 1'b1, 8'hA5},  // pop empty R6
    {1'b0, 1'b0, 8'h00, 6'd0, 1'b0, 1'b1, 1'b0, 8'hA5}   // idle clears err R8
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic q, input logic [7:0] d);
    @(negedge clk);
    push_i = p;
    pop_i  = q;
    din_i  = d;
    @(negedge clk);
    push_i = 1'b0;
    pop_i  = 1'b0;
  endtask

  task automatic do_reset();
    rst_n  = 1'b0;
    push_i = 1'b0;
    pop_i  = 1'b0;
    din_i  = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 7 + 3) & 8'hFF);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    chk("R1", "sp", sp_o, 0);
    chk("R1", "empty", empty_o, 1);
    chk("R1", "full", full_o, 0);
    chk("R1", "err", err_o, 0);
    chk("R1", "dout", dout_o, 0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [26:0] v;
      v = VEC[i];
      step(v[26], v[25], v[24:17]);
      chk("R2/R3 table", "sp", sp_o, v[16:11]);
      chk("R9 table", "full", full_o, v[10]);
      chk("R9 table", "empty", empty_o, v[9]);
      chk("R8 table", "err", err_o, v[8]);
      chk("R10 table", "dout", dout_o, v[7:0]);
    end

    // Reset in mid-stream
    step(1'b1, 1'b0, 8'h5A);
    step(1'b0, 1'b1, 8'h00);
    step(1'b1, 1'b0, 8'h11);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "sp async", sp_o, 0);
    chk("R1", "empty async", empty_o, 1);
    chk("R1", "dout async", dout_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "sp after release", sp_o, 0);

    // Fill all 64 entries
    for (int k = 0; k < 64; k++) begin
      step(1'b1, 1'b0, pat(k));
      chk("R2 R9 fill", "sp", sp_o, (k + 1) % 64);
      chk("R9 fill", "full", full_o, (k == 63) ? 1 : 0);
      chk("R2 fill", "empty", empty_o, 0);
    end

    // Push while full
    step(1'b1, 1'b0, 8'hEE);
    chk("R5", "err", err_o, 1);
    chk("R5", "sp", sp_o, 0);
    chk("R5", "full", full_o, 1);
    chk("R5", "dout", dout_o, 0);

    // Push and pop together while full
    step(1'b1, 1'b1, 8'hDD);
    chk("R7", "err", err_o, 1);
    chk("R7", "sp", sp_o, 0);
    chk("R7", "full", full_o, 1);

    // Drain in reverse order; first pop returns the word at address 0
    for (int k = 63; k >= 0; k--) begin
      step(1'b0, 1'b1, 8'h00);
      chk("R4 R3 drain", "dout", dout_o, pat(k));
      chk("R3 drain", "sp", sp_o, k);
      chk("R3 drain", "full", full_o, 0);
      chk("R3 drain", "empty", empty_o, (k == 0) ? 1 : 0);
      chk("R8 drain", "err", err_o, 0);
    end

    // Pop while empty after a full cycle
    step(1'b0, 1'b1, 8'h00);
    chk("R6", "err", err_o, 1);
    chk("R6", "dout", dout_o, pat(0));
    chk("R6", "sp", sp_o, 0);
    step(1'b0, 1'b0, 8'h00);
    chk("R8", "err low", err_o, 0);

    finish_run();
  end

endmodule